// File: doc/BRIEF.md
# Five-Stage Pipelined Load/Store Core

This block is a small 32-bit load/store processor core. Each instruction passes through five stages: fetch, decode with operand read, execute (ALU work or address arithmetic), data memory access, and register write-back. Each stage takes one clock. Four stage registers separate the stages, and each carries a fixed set of fields. The core executes five register-to-register ALU operations, a word load, a word store and a branch-if-equal. Word addressing drops the low two address bits.

The instruction array and the data array are internal. Writes to them are synchronous and reads are combinational. A load port fills both arrays while the core is held in reset. Two inspection ports return a data-memory word and a register value. The core has no hazard detection, no forwarding and no stalls. A program must therefore keep at least two unrelated instructions between a producer and its consumer, so that the consumer decodes no earlier than the cycle in which the producer writes back.

A taken branch redirects fetch only when it reaches the memory stage. The three instructions fetched behind it always complete. The retire port pulses once per completed instruction. With it come the instruction's address, whether it wrote a register, which register it wrote, and the value it wrote.

Top module: `risc5_core`

## Requirements
- R1: While rst_n is low, and on the first three cycles after it rises, retire_valid is 0. Reset sets the fetch address to 0 and turns every stage register into a bubble that writes nothing.
- R2: The instruction at address 0 retires on the fifth cycle after reset release, which is after four rising edges. From then on, retire_valid is 1 on every cycle and instructions retire in fetch order, with retire_pc giving each one's address.
- R3: Opcode 000000 is an ALU operation. Its sources are the registers named in bits 25:21 and 20:16, and it writes the register named in bits 15:11. Function code (bits 5:0) 100000 selects add, 100010 sub, 100100 and, 100101 or, and 101010 signed set-less-than, which gives 1 or 0.
- R4: Opcode 100011 loads into the register named in bits 20:16 the data word at the byte address formed by register[25:21] plus the sign-extended bits 15:0.
- R5: Opcode 101011 writes register[20:16] to the data word at that same kind of address, and writes no register. A later load from that address returns the stored value.
- R6: Opcode 000100 compares register[25:21] with register[20:16]. When they are equal, fetch continues at the branch address + 4 + (sign-extended bits 15:0 shifted left by 2). The redirect takes effect when the branch leaves the memory stage, and the three instructions that follow the branch always complete.
- R7: When the two registers of opcode 000100 differ, fetch continues in sequence.
- R8: Register 0 always reads as 0. An instruction that names register 0 as its destination retires with retire_wen at 0.
- R9: A register written back in a cycle returns the new value to a read of the same register in that same cycle.
- R10: An all-zero word, any other opcode, and an opcode 000000 word with an unlisted function code each retire as a no-op. Such an instruction writes no register and no memory.
- R11: On each retirement, retire_wen is 1 exactly when a register is written, and in that case retire_rd and retire_data give the register number and the value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| load_imem_en | input | 1 | Write load_data into the instruction array at load_addr |
| load_dmem_en | input | 1 | Write load_data into the data array at load_addr |
| load_addr | input | LAW | Word index for array loading |
| load_data | input | 32 | Word to load |
| peek_daddr | input | DAW | Word index of the data array to inspect |
| peek_ddata | output | 32 | Data array word at peek_daddr |
| peek_reg | input | 5 | Register number to inspect |
| peek_rdata | output | 32 | Value of register peek_reg |
| retire_valid | output | 1 | One instruction completes this cycle |
| retire_pc | output | 32 | Address of the completing instruction |
| retire_wen | output | 1 | The completing instruction writes a register |
| retire_rd | output | 5 | Register written |
| retire_data | output | 32 | Value written |

## Verification
The two functions that share a cycle are write-back of one instruction and the operand read of a later instruction that names the same register. The test program provokes this by placing each consumer exactly three instructions after its producer, in a chain of loads followed by ALU operations. The consumer's result is then judged against the value the bench computes from the new operand, not the stale one. A second overlap is a taken branch that redirects fetch while its three shadow instructions are still in flight. The retire address sequence shows that the shadow instructions completed and that the skipped ones did not.

// File: rtl/risc5_pkg.sv
package risc5_pkg;
    localparam int XLEN  = 32;
    localparam int RIDX_W = 5;

    localparam logic [5:0] OP_ALU   = 6'b000000;
    localparam logic [5:0] OP_LOAD  = 6'b100011;
    localparam logic [5:0] OP_STORE = 6'b101011;
    localparam logic [5:0] OP_BEQ   = 6'b000100;

    localparam logic [5:0] FN_ADD = 6'b100000;
    localparam logic [5:0] FN_SUB = 6'b100010;
    localparam logic [5:0] FN_AND = 6'b100100;
    localparam logic [5:0] FN_OR  = 6'b100101;
    localparam logic [5:0] FN_SLT = 6'b101010;

    typedef enum logic [2:0] {K_NOP, K_ALU, K_LOAD, K_STORE, K_BRANCH} kind_e;
    typedef enum logic [2:0] {A_ADD, A_SUB, A_AND, A_OR, A_SLT} aluop_e;

    typedef struct packed {
        logic            valid;
        logic [XLEN-1:0] pc4;
        logic [XLEN-1:0] iw;
    } fd_reg_t;

    typedef struct packed {
        logic              valid;
        kind_e             kind;
        aluop_e            op;
        logic [XLEN-1:0]   pc4;
        logic [XLEN-1:0]   opa;
        logic [XLEN-1:0]   opb;
        logic [XLEN-1:0]   imm;
        logic [RIDX_W-1:0] rt;
        logic [RIDX_W-1:0] rd;
    } dx_reg_t;

    typedef struct packed {
        logic              valid;
        kind_e             kind;
        logic [XLEN-1:0]   pc4;
        logic [XLEN-1:0]   target;
        logic              zero;
        logic [XLEN-1:0]   res;
        logic [XLEN-1:0]   sdata;
        logic [RIDX_W-1:0] dst;
    } xm_reg_t;

    typedef struct packed {
        logic              valid;
        kind_e             kind;
        logic [XLEN-1:0]   pc4;
        logic [XLEN-1:0]   mdata;
        logic [XLEN-1:0]   res;
        logic [RIDX_W-1:0] dst;
    } mw_reg_t;
endpackage

// File: rtl/risc5_decode.sv
module risc5_decode
    import risc5_pkg::*;
(
    input  logic [XLEN-1:0]   iw,
    output kind_e             kind,
    output aluop_e            op,
    output logic [RIDX_W-1:0] rs,
    output logic [RIDX_W-1:0] rt,
    output logic [RIDX_W-1:0] rd,
    output logic [XLEN-1:0]   imm
);
    logic unused_shamt;
    assign unused_shamt = ^iw[10:6];

    assign rs  = iw[25:21];
    assign rt  = iw[20:16];
    assign rd  = iw[15:11];
    assign imm = {{(XLEN-16){iw[15]}}, iw[15:0]};

    always_comb begin
        kind = K_NOP;
        op   = A_ADD;
        unique case (iw[31:26])
            OP_ALU: begin
                kind = K_ALU;
                unique case (iw[5:0])
                    FN_ADD:  op = A_ADD;
                    FN_SUB:  op = A_SUB;
                    FN_AND:  op = A_AND;
                    FN_OR:   op = A_OR;
                    FN_SLT:  op = A_SLT;
                    default: kind = K_NOP;   // R10
                endcase
            end
            OP_LOAD:  kind = K_LOAD;
            OP_STORE: kind = K_STORE;
            OP_BEQ: begin
                kind = K_BRANCH;
                op   = A_SUB;
            end
            default:  kind = K_NOP;
        endcase
    end
endmodule

// File: rtl/risc5_alu.sv
module risc5_alu
    import risc5_pkg::*;
#(
    parameter int W = XLEN
) (
    input  aluop_e       op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y,
    output logic         zero
);
    always_comb begin
        unique case (op)
            A_ADD:   y = a + b;
            A_SUB:   y = a - b;
            A_AND:   y = a & b;
            A_OR:    y = a | b;
            A_SLT:   y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = a + b;
        endcase
    end
    assign zero = (y == '0);
endmodule

// File: rtl/risc5_regfile.sv
module risc5_regfile #(
    parameter int NREG  = 32,
    parameter int WIDTH = 32,
    parameter int NRD   = 3,
    localparam int AW   = $clog2(NREG)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [AW-1:0]              waddr,
    input  logic [WIDTH-1:0]           wdata,
    input  logic [NRD-1:0][AW-1:0]     raddr,
    output logic [NRD-1:0][WIDTH-1:0]  rdata
);
    logic [WIDTH-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (we && waddr != '0) begin
            regs[waddr] <= wdata;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rdata[p] = (raddr[p] == '0)                 ? '0    :
                          (we && waddr == raddr[p])        ? wdata :
                                                             regs[raddr[p]];
    end

    AST_RF_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (we && waddr != '0) |=> (regs[$past(waddr)] == $past(wdata))); // R9
endmodule

// File: rtl/risc5_core.sv
module risc5_core
    import risc5_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64,
    localparam int IAW = $clog2(IMEM_WORDS),
    localparam int DAW = $clog2(DMEM_WORDS),
    localparam int LAW = (IAW > DAW) ? IAW : DAW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_imem_en,
    input  logic              load_dmem_en,
    input  logic [LAW-1:0]    load_addr,
    input  logic [XLEN-1:0]   load_data,
    input  logic [DAW-1:0]    peek_daddr,
    output logic [XLEN-1:0]   peek_ddata,
    input  logic [RIDX_W-1:0] peek_reg,
    output logic [XLEN-1:0]   peek_rdata,
    output logic              retire_valid,
    output logic [XLEN-1:0]   retire_pc,
    output logic              retire_wen,
    output logic [RIDX_W-1:0] retire_rd,
    output logic [XLEN-1:0]   retire_data
);
    logic [XLEN-1:0] imem [IMEM_WORDS];
    logic [XLEN-1:0] dmem [DMEM_WORDS];

    logic [XLEN-1:0] pc_q, pc_d;
    fd_reg_t fd_q, fd_d;
    dx_reg_t dx_q, dx_d;
    xm_reg_t xm_q, xm_d;
    mw_reg_t mw_q, mw_d;

    // decode stage
    kind_e             dec_kind;
    aluop_e            dec_op;
    logic [RIDX_W-1:0] dec_rs, dec_rt, dec_rd;
    logic [XLEN-1:0]   dec_imm;

    risc5_decode u_decode (
        .iw   (fd_q.iw),
        .kind (dec_kind),
        .op   (dec_op),
        .rs   (dec_rs),
        .rt   (dec_rt),
        .rd   (dec_rd),
        .imm  (dec_imm)
    );

    // write-back stage
    logic              wb_wen;
    logic [XLEN-1:0]   wb_data;
    logic [2:0][RIDX_W-1:0] rf_raddr;
    logic [2:0][XLEN-1:0]   rf_rdata;

    assign wb_wen  = mw_q.valid && (mw_q.kind == K_ALU || mw_q.kind == K_LOAD)
                     && (mw_q.dst != '0);
    assign wb_data = (mw_q.kind == K_LOAD) ? mw_q.mdata : mw_q.res;
    assign rf_raddr = {peek_reg, dec_rt, dec_rs};

    risc5_regfile #(.NREG(32), .WIDTH(XLEN), .NRD(3)) u_regfile (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wb_wen),
        .waddr (mw_q.dst),
        .wdata (wb_data),
        .raddr (rf_raddr),
        .rdata (rf_rdata)
    );

    // execute stage
    logic [XLEN-1:0] alu_b, alu_y;
    logic            alu_zero;
    assign alu_b = (dx_q.kind == K_LOAD || dx_q.kind == K_STORE) ? dx_q.imm : dx_q.opb;

    risc5_alu #(.W(XLEN)) u_alu (
        .op   (dx_q.op),
        .a    (dx_q.opa),
        .b    (alu_b),
        .y    (alu_y),
        .zero (alu_zero)
    );

    // memory stage
    logic            take_branch, store_en;
    logic [DAW-1:0]  mem_idx;
    logic [XLEN-1:0] mem_rdata;
    assign take_branch = xm_q.valid && xm_q.kind == K_BRANCH && xm_q.zero;
    assign store_en    = xm_q.valid && xm_q.kind == K_STORE;
    assign mem_idx     = xm_q.res[DAW+1:2];
    assign mem_rdata   = dmem[mem_idx];

    logic unused_bits;
    assign unused_bits = ^{pc_q[XLEN-1:IAW+2], pc_q[1:0], xm_q.res[XLEN-1:DAW+2], xm_q.res[1:0]};

    // next-state of every stage register
    always_comb begin
        pc_d = take_branch ? xm_q.target : pc_q + 32'd4;

        fd_d.valid = 1'b1;
        fd_d.pc4   = pc_q + 32'd4;
        fd_d.iw    = imem[pc_q[IAW+1:2]];

        dx_d.valid = fd_q.valid;
        dx_d.kind  = fd_q.valid ? dec_kind : K_NOP;
        dx_d.op    = dec_op;
        dx_d.pc4   = fd_q.pc4;
        dx_d.opa   = rf_rdata[0];
        dx_d.opb   = rf_rdata[1];
        dx_d.imm   = dec_imm;
        dx_d.rt    = dec_rt;
        dx_d.rd    = dec_rd;

        xm_d.valid  = dx_q.valid;
        xm_d.kind   = dx_q.kind;
        xm_d.pc4    = dx_q.pc4;
        xm_d.target = dx_q.pc4 + (dx_q.imm << 2);
        xm_d.zero   = alu_zero;
        xm_d.res    = alu_y;
        xm_d.sdata  = dx_q.opb;
        unique case (dx_q.kind)
            K_ALU:   xm_d.dst = dx_q.rd;
            K_LOAD:  xm_d.dst = dx_q.rt;
            default: xm_d.dst = '0;
        endcase

        mw_d.valid = xm_q.valid;
        mw_d.kind  = xm_q.kind;
        mw_d.pc4   = xm_q.pc4;
        mw_d.mdata = mem_rdata;
        mw_d.res   = xm_q.res;
        mw_d.dst   = xm_q.dst;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
            fd_q <= '0;
            dx_q <= '0;
            xm_q <= '0;
            mw_q <= '0;
        end else begin
            pc_q <= pc_d;
            fd_q <= fd_d;
            dx_q <= dx_d;
            xm_q <= xm_d;
            mw_q <= mw_d;
        end
    end

    always_ff @(posedge clk) begin
        if (load_imem_en) begin
            imem[load_addr[IAW-1:0]] <= load_data;
        end
        if (store_en) begin
            dmem[mem_idx] <= xm_q.sdata;
        end else if (load_dmem_en) begin
            dmem[load_addr[DAW-1:0]] <= load_data;
        end
    end

    assign peek_ddata   = dmem[peek_daddr];
    assign peek_rdata   = rf_rdata[2];
    assign retire_valid = mw_q.valid;
    assign retire_pc    = mw_q.pc4 - 32'd4;
    assign retire_wen   = wb_wen;
    assign retire_rd    = mw_q.dst;
    assign retire_data  = wb_data;

    AST_RETIRE_FOLLOWS_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        xm_q.valid |=> retire_valid); // R2
    AST_LOAD_RETURNS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (xm_q.valid && xm_q.kind == K_LOAD && xm_q.dst != '0)
        |=> (retire_wen && retire_data == $past(mem_rdata))); // R4
    AST_STORE_NO_REGWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        store_en |=> !retire_wen); // R5
    AST_BRANCH_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        take_branch |=> (pc_q == $past(xm_q.target))); // R6
    AST_SEQ_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        !take_branch |=> (pc_q == $past(pc_q) + 32'd4)); // R7
endmodule

// File: tb/risc5_core_bench.sv
module risc5_core_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_imem_en = 1'b0, load_dmem_en = 1'b0;
    logic [5:0]  load_addr = '0;
    logic [31:0] load_data = '0;
    logic [5:0]  peek_daddr = '0;
    logic [31:0] peek_ddata;
    logic [4:0]  peek_reg = '0;
    logic [31:0] peek_rdata;
    logic        retire_valid, retire_wen;
    logic [31:0] retire_pc, retire_data;
    logic [4:0]  retire_rd;

    risc5_core u_risc5_core (
        .clk(clk), .rst_n(rst_n),
        .load_imem_en(load_imem_en), .load_dmem_en(load_dmem_en),
        .load_addr(load_addr), .load_data(load_data),
        .peek_daddr(peek_daddr), .peek_ddata(peek_ddata),
        .peek_reg(peek_reg), .peek_rdata(peek_rdata),
        .retire_valid(retire_valid), .retire_pc(retire_pc), .retire_wen(retire_wen),
        .retire_rd(retire_rd), .retire_data(retire_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    int edges = 0;
    bit done = 1'b0;

    logic [31:0] q_pc[$];
    logic        q_wen[$];
    logic [4:0]  q_rd[$];
    logic [31:0] q_data[$];
    string       q_tag[$];

    function automatic logic [31:0] enc_r(logic [4:0] rs, logic [4:0] rt, logic [4:0] rd, logic [5:0] fn);
        return {6'b000000, rs, rt, rd, 5'b00000, fn};
    endfunction

    function automatic logic [31:0] enc_i(logic [5:0] op, logic [4:0] rs, logic [4:0] rt, logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic load_word(input bit to_imem, input int idx, input logic [31:0] d);
        @(negedge clk); #1;
        load_imem_en = to_imem;
        load_dmem_en = !to_imem;
        load_addr    = idx[5:0];
        load_data    = d;
        @(negedge clk); #1;
        load_imem_en = 1'b0;
        load_dmem_en = 1'b0;
    endtask

    // driver: place an instruction and, if it should complete, push its expected retirement
    task automatic put(input int pc, input logic [31:0] w, input bit retires,
                       input bit wen, input int rd, input logic [31:0] d, input string tag);
        load_word(1'b1, pc / 4, w);
        if (retires) begin
            q_pc.push_back(pc);
            q_wen.push_back(wen);
            q_rd.push_back(rd[4:0]);
            q_data.push_back(d);
            q_tag.push_back(tag);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) edges <= 0;
        else        edges <= edges + 1;
    end

    // monitor: compare the retire stream with the scoreboard
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (edges < 4) begin
                check(retire_valid == 1'b0, "R1 bubble before first retire", {31'b0, retire_valid}, 0);
            end else begin
                check(retire_valid == 1'b1, "R2 retire every cycle", {31'b0, retire_valid}, 1);
            end
            if (retire_valid) begin
                if (q_pc.size() != 0) begin
                    logic [31:0] e_pc, e_d;
                    logic e_w;
                    logic [4:0] e_rd;
                    string tg;
                    e_pc = q_pc.pop_front();
                    e_w  = q_wen.pop_front();
                    e_rd = q_rd.pop_front();
                    e_d  = q_data.pop_front();
                    tg   = q_tag.pop_front();
                    check(retire_pc == e_pc, {tg, " R2 retire_pc"}, retire_pc, e_pc);
                    check(retire_wen == e_w, {tg, " R11 retire_wen"}, {31'b0, retire_wen}, {31'b0, e_w});
                    if (e_w && retire_wen) begin
                        check(retire_rd == e_rd, {tg, " R11 retire_rd"}, {27'b0, retire_rd}, {27'b0, e_rd});
                        check(retire_data == e_d, {tg, " R11 retire_data"}, retire_data, e_d);
                    end
                end else begin
                    check(retire_wen == 1'b0, "R10 trailing zero word writes nothing", {31'b0, retire_wen}, 0);
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(retire_valid == 1'b0, "R1 retire_valid in reset", {31'b0, retire_valid}, 0);

        load_word(1'b0, 0, 32'd5);
        load_word(1'b0, 1, 32'd3);
        load_word(1'b0, 2, 32'hFFFF_FFF0);
        load_word(1'b0, 3, 32'h0F0F_0F00);
        load_word(1'b0, 4, 32'h0);
        load_word(1'b0, 5, 32'h0);

        put(  0, enc_i(6'b100011, 0, 1, 16'd0),  1, 1, 1, 32'd5, "R4 load");
        put(  4, enc_i(6'b100011, 0, 2, 16'd4),  1, 1, 2, 32'd3, "R4 load");
        put(  8, enc_i(6'b100011, 0, 3, 16'd8),  1, 1, 3, 32'hFFFF_FFF0, "R4 load");
        put( 12, enc_i(6'b100011, 0, 4, 16'd12), 1, 1, 4, 32'h0F0F_0F00, "R4 load");
        put( 16, enc_r(1, 2, 5, 6'b100000), 1, 1, 5, 32'd8, "R9 add same-cycle read");
        put( 20, enc_r(1, 2, 6, 6'b100010), 1, 1, 6, 32'd2, "R3 sub");
        put( 24, enc_r(4, 3, 7, 6'b100100), 1, 1, 7, 32'h0F0F_0F00, "R9 and same-cycle read");
        put( 28, enc_r(4, 5, 8, 6'b100101), 1, 1, 8, 32'h0F0F_0F08, "R3 or");
        put( 32, enc_r(3, 1, 9, 6'b101010), 1, 1, 9, 32'd1, "R3 slt negative");
        put( 36, enc_r(1, 3, 10, 6'b101010), 1, 1, 10, 32'd0, "R3 slt signed");
        put( 40, enc_i(6'b101011, 0, 8, 16'd16), 1, 0, 0, 0, "R5 store");
        put( 44, enc_r(1, 2, 0, 6'b100000), 1, 0, 0, 0, "R8 write r0");
        put( 48, enc_i(6'b100011, 0, 11, 16'd16), 1, 1, 11, 32'h0F0F_0F08, "R5 load after store");
        put( 52, enc_i(6'b000100, 1, 1, 16'd6),  1, 0, 0, 0, "R6 taken branch");
        put( 56, enc_r(1, 1, 12, 6'b100000), 1, 1, 12, 32'd10, "R6 shadow 1");
        put( 60, 32'h0000_0000,              1, 0, 0, 0, "R10 zero word");
        put( 64, enc_r(2, 1, 13, 6'b100010), 1, 1, 13, 32'hFFFF_FFFE, "R6 shadow 3");
        put( 68, enc_r(1, 1, 14, 6'b100000), 0, 0, 0, 0, "");
        put( 72, enc_r(1, 1, 14, 6'b100000), 0, 0, 0, 0, "");
        put( 76, enc_r(1, 1, 14, 6'b100000), 0, 0, 0, 0, "");
        put( 80, enc_i(6'b000100, 1, 2, 16'd4),  1, 0, 0, 0, "R7 branch not taken");
        put( 84, enc_r(2, 2, 15, 6'b100000), 1, 1, 15, 32'd6, "R7 after beq");
        put( 88, enc_r(3, 4, 16, 6'b100100), 1, 1, 16, 32'h0F0F_0F00, "R7 after beq");
        put( 92, enc_r(0, 1, 17, 6'b100101), 1, 1, 17, 32'd5, "R8 r0 reads zero");
        put( 96, enc_r(2, 1, 18, 6'b101010), 1, 1, 18, 32'd1, "R7 sequential fetch");
        put(100, enc_i(6'b101011, 0, 13, 16'd20), 1, 0, 0, 0, "R5 store");
        put(104, enc_i(6'b100011, 5, 19, 16'hFFFC), 1, 1, 19, 32'd3, "R4 negative offset");
        put(108, enc_r(1, 2, 9, 6'b000110), 1, 0, 0, 0, "R10 unlisted function");
        put(112, 32'hFC00_0000,              1, 0, 0, 0, "R10 unknown opcode");

        @(negedge clk); #1;
        rst_n = 1'b1;

        while (q_pc.size() != 0) @(negedge clk);
        repeat (6) @(negedge clk);
        done = 1'b1;

        #1; peek_daddr = 6'd4; #1;
        check(peek_ddata == 32'h0F0F_0F08, "R5 stored word", peek_ddata, 32'h0F0F_0F08);
        peek_daddr = 6'd5; #1;
        check(peek_ddata == 32'hFFFF_FFFE, "R5 stored word", peek_ddata, 32'hFFFF_FFFE);
        peek_daddr = 6'd1; #1;
        check(peek_ddata == 32'd3, "R4 load leaves memory", peek_ddata, 32'd3);
        peek_reg = 5'd0; #1;
        check(peek_rdata == 32'd0, "R8 r0 stays zero", peek_rdata, 0);
        peek_reg = 5'd9; #1;
        check(peek_rdata == 32'd1, "R10 unlisted function kept r9", peek_rdata, 1);
        peek_reg = 5'd12; #1;
        check(peek_rdata == 32'd10, "R6 shadow result kept", peek_rdata, 10);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", q_pc.size(), 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule